// File: doc/BRIEF.md
# RTC Holding Register Synchronizer

This block holds a calendar clock and keeps it apart from the registers that software sees. A prescaler counts pulses of a 32.768 kHz time base and produces one enable per second. A calendar core keeps seconds, minutes, hours, weekday, day of month, month and two-digit year in BCD. A set of holding registers sits between the core and a plain register port. Software reaches the core only through these holding registers.

Two control bits set how the holding registers and the core exchange data. When the snapshot bit (SNAP) goes from 0 to 1, the holding registers are loaded with the core time. If a second falls in that same cycle, the loaded value already includes it. The holding registers then stay frozen until SNAP is cleared. When the lock bit (LOCK) is set, the core stops counting and the holding registers accept writes. When LOCK is cleared, the staged values are loaded into the core, and counting resumes from them. With both bits at 0, the holding registers follow the core on every cycle.

The register port is a control interface and carries no stream. There is no valid/ready pairing and no back-pressure. A write takes effect at the clock edge where `wr_en` is high. Read data is combinational from `addr`.

Top module: `rtc_sync_top`

## Requirements
- R1: Only cycles where `tick_in` is high advance the divider. The second enable is produced on every DIV-th tick after reset. The divider keeps its phase while LOCK is set and when a commit happens.
- R2: At each second the core advances in BCD. Seconds and minutes wrap from 59 to 00 and carry into the next field. Hours wrap from 23 to 00 and carry into the weekday and the day of month.
- R3: The weekday counts 01 to 07 and wraps from 07 to 01.
- R4: After the last day of a month, the day of month becomes 01 and the month advances. Month lengths are 31/28/31/30/31/30/31/31/30/31/30/31. February has 29 days when the year is a multiple of four, and year 00 counts as a multiple of four. Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R5: The register map is as follows. Address 0 is control: bit 0 is SNAP and bit 1 is LOCK, and the other bits read 0. Address 1 holds seconds, 2 minutes, 3 hours (24-hour), 4 weekday, 5 day of month, 6 month and 7 year. All of them are read through `rdata`.
- R6: While SNAP and LOCK are both 0, the time registers read the current core time. A read in the cycle after a second edge shows the new value.
- R7: A 0-to-1 write of SNAP, with LOCK at 0, copies the core time into the holding registers. While SNAP stays 1, reads return that copy even as the core advances.
- R8: If a second enable arrives in the same cycle as a rising SNAP, the copy includes that second.
- R9: While LOCK is 1, writes to addresses 1 to 7 are staged and the core does not count. While LOCK is 0, writes to addresses 1 to 7 are ignored.
- R10: A write that clears LOCK loads the staged values into the core. A second enable in that same cycle is not applied. Counting resumes from the loaded values.
- R11: After reset, control reads 00 and the time reads 00:00:00, weekday 01, day 01, month 01, year 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | One-cycle pulse per period of the 32.768 kHz time base |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address (0 control, 1..7 time fields) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |

## Verification
There are two cases where a second enable can fall in the same clock cycle as a control write. In the first, SNAP rises in the same cycle as the second enable. In the second, LOCK falls in the same cycle as the second enable. The bench runs a divider model of its own, so it can tick the block until the enable is one tick away. It then issues the control write together with that final tick. For the SNAP case, the frozen copy must show the incremented second. For the LOCK case, the core must hold exactly the staged value and advance only at the next full divider period. A sweep over every month and several years starts each case at the last second of the month and checks all seven fields across the rollover.

// File: rtl/rtc_sync_pkg.sv
package rtc_sync_pkg;
  localparam int NFLD   = 7;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HR   = 2;
  localparam int F_DOW  = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YR   = 6;

  typedef logic [NFLD-1:0][7:0] rtc_time_t;

  // year 00, month 01, day 01, weekday 01, 00:00:00
  localparam rtc_time_t RST_TIME = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
    return (8'(b[7:4]) * 8'd10) + 8'(b[3:0]);
  endfunction

  function automatic logic [7:0] bin_to_bcd(input logic [7:0] v);
    logic [7:0] tens, ones;
    tens = v / 8'd10;
    ones = v % 8'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [7:0] days_of(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'd2:                     return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:  return 8'd30;
      default:                  return 8'd31;
    endcase
  endfunction

  function automatic rtc_time_t time_step(input rtc_time_t t);
    logic [7:0] s, m, h, w, d, mo, y;
    rtc_time_t r;
    s  = bcd_to_bin(t[F_SEC]);
    m  = bcd_to_bin(t[F_MIN]);
    h  = bcd_to_bin(t[F_HR]);
    w  = bcd_to_bin(t[F_DOW]);
    d  = bcd_to_bin(t[F_DATE]);
    mo = bcd_to_bin(t[F_MON]);
    y  = bcd_to_bin(t[F_YR]);
    s = s + 8'd1;
    if (s >= 8'd60) begin
      s = 8'd0;
      m = m + 8'd1;
      if (m >= 8'd60) begin
        m = 8'd0;
        h = h + 8'd1;
        if (h >= 8'd24) begin
          h = 8'd0;
          w = (w >= 8'd7) ? 8'd1 : w + 8'd1;
          d = d + 8'd1;
          if (d > days_of(mo, y)) begin
            d  = 8'd1;
            mo = mo + 8'd1;
            if (mo > 8'd12) begin
              mo = 8'd1;
              y  = (y >= 8'd99) ? 8'd0 : y + 8'd1;
            end
          end
        end
      end
    end
    r[F_SEC]  = bin_to_bcd(s);
    r[F_MIN]  = bin_to_bcd(m);
    r[F_HR]   = bin_to_bcd(h);
    r[F_DOW]  = bin_to_bcd(w);
    r[F_DATE] = bin_to_bcd(d);
    r[F_MON]  = bin_to_bcd(mo);
    r[F_YR]   = bin_to_bcd(y);
    return r;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic sec_pulse
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign sec_pulse = tick_in && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick_in) cnt_q <= sec_pulse ? '0 : cnt_q + 1'b1;
  end

  // R1
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R1
  pulse_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> (cnt_q == '0));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_sync_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sec_pulse,
  input  logic      lock,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t time_nx,
  output rtc_time_t time_q
);
  always_comb begin
    if (load)                   time_nx = load_val;
    else if (sec_pulse && !lock) time_nx = time_step(time_q);
    else                        time_nx = time_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) time_q <= RST_TIME;
    else        time_q <= time_nx;
  end

  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !load) |=> $stable(time_q));

  // R10
  commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (time_q == $past(load_val)));

  // R2
  sec_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !lock && !load) |=> (time_q[F_SEC] != $past(time_q[F_SEC])));
endmodule

// File: rtl/rtc_holding.sv
module rtc_holding
  import rtc_sync_pkg::*;
#(
  parameter int NF = NFLD
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [$clog2(NF)-1:0]  wr_idx,
  input  logic [7:0]             wr_data,
  input  logic                   snap,
  input  logic                   track,
  input  rtc_time_t              core_nx,
  output rtc_time_t              hold_q
);
  localparam int IW = $clog2(NF);

  for (genvar g = 0; g < NF; g++) begin : g_fld
    always_ff @(posedge clk) begin
      if (!rst_n)                                hold_q[g] <= RST_TIME[g];
      else if (wr_en && (wr_idx == IW'(g)))      hold_q[g] <= wr_data;
      else if (snap || track)                    hold_q[g] <= core_nx[g];
    end
  end
endmodule

// File: rtl/rtc_sync_top.sv
module rtc_sync_top
  import rtc_sync_pkg::*;
#(
  parameter int DIV = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_in,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam int B_SNAP = 0;
  localparam int B_LOCK = 1;

  logic [1:0] ctrl_q, ctrl_nx;
  logic       ctrl_wr, fld_wr, snap_rise, lock_fall, core_lock, track;
  logic       sec_pulse;
  logic [2:0] fld_idx;
  rtc_time_t  core_q, core_nx, hold_q;

  assign ctrl_wr   = wr_en && (addr == 3'd0);
  assign ctrl_nx   = ctrl_wr ? wdata[1:0] : ctrl_q;
  assign snap_rise = ctrl_nx[B_SNAP] && !ctrl_q[B_SNAP] && !ctrl_nx[B_LOCK];
  assign lock_fall = ctrl_q[B_LOCK] && !ctrl_nx[B_LOCK];
  assign core_lock = ctrl_q[B_LOCK] || ctrl_nx[B_LOCK];
  assign track     = (ctrl_nx == 2'b00) && !lock_fall;
  assign fld_wr    = wr_en && (addr != 3'd0) && ctrl_q[B_LOCK];
  assign fld_idx   = addr - 3'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= 2'b00;
    else        ctrl_q <= ctrl_nx;
  end

  rtc_prescaler #(.DIV(DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_in   (tick_in),
    .sec_pulse (sec_pulse)
  );

  rtc_calendar u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_pulse (sec_pulse),
    .lock      (core_lock),
    .load      (lock_fall),
    .load_val  (hold_q),
    .time_nx   (core_nx),
    .time_q    (core_q)
  );

  rtc_holding #(.NF(NFLD)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (fld_wr),
    .wr_idx  (fld_idx),
    .wr_data (wdata),
    .snap    (snap_rise),
    .track   (track),
    .core_nx (core_nx),
    .hold_q  (hold_q)
  );

  always_comb begin
    if (addr == 3'd0) rdata = {6'b0, ctrl_q};
    else              rdata = hold_q[fld_idx];
  end

  // R7
  snap_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[B_SNAP] && ctrl_nx[B_SNAP] && !ctrl_q[B_LOCK] && !ctrl_nx[B_LOCK])
      |=> $stable(hold_q));

  // R8
  snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_rise |=> (hold_q == core_q));

  // R6
  live_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q == 2'b00 && $past(ctrl_q) == 2'b00) |-> (hold_q == core_q));
endmodule

// File: tb/rtc_sync_top_bench.sv
module rtc_sync_top_bench;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;

  int checks = 0;
  int errors = 0;

  int bt[7];
  int staged[7];
  int ex[7];
  int bpre = 0;
  bit wlock = 0;
  bit last_pulse = 0;

  always #10 clk = ~clk;

  rtc_sync_top #(.DIV(DIV)) u_rtc_sync_top (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  function automatic int tobcd(int v);
    return (v / 10) * 16 + (v % 10);
  endfunction

  function automatic int frombcd(int b);
    return (b / 16) * 10 + (b % 16);
  endfunction

  function automatic int mdays(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic binc();
    bt[0]++;
    if (bt[0] == 60) begin
      bt[0] = 0; bt[1]++;
      if (bt[1] == 60) begin
        bt[1] = 0; bt[2]++;
        if (bt[2] == 24) begin
          bt[2] = 0;
          bt[3] = (bt[3] == 7) ? 1 : bt[3] + 1;
          bt[4]++;
          if (bt[4] > mdays(bt[5], bt[6])) begin
            bt[4] = 1; bt[5]++;
            if (bt[5] > 12) begin
              bt[5] = 1;
              bt[6] = (bt[6] == 99) ? 0 : bt[6] + 1;
            end
          end
        end
      end
    end
  endtask

  task automatic chk(int act, int exp, string req, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(bit tk, bit wr, int a, int d);
    bit pulse, neww, commit, lockeff;
    @(negedge clk);
    tick_in = tk; wr_en = wr; addr = 3'(a); wdata = 8'(d);
    @(posedge clk);
    pulse = 0;
    if (tk) begin
      if (bpre == DIV - 1) begin bpre = 0; pulse = 1; end
      else bpre++;
    end
    if (wr && a == 0) begin
      neww = d[1]; commit = wlock && !neww; lockeff = wlock || neww;
    end else begin
      neww = wlock; commit = 0; lockeff = wlock;
    end
    if (wr && a != 0 && wlock) staged[a-1] = frombcd(d);
    if (commit) bt = staged;
    else if (pulse && !lockeff) binc();
    if (wr && a == 0 && neww && !wlock) staged = bt;
    wlock = neww;
    last_pulse = pulse;
    #1;
    tick_in = 0; wr_en = 0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    wr_en = 0; tick_in = 0; addr = 3'(a);
    #1;
    v = int'(rdata);
  endtask

  task automatic check_time(string req);
    int v;
    for (int i = 0; i < 7; i++) begin
      rd(i + 1, v);
      chk(v, tobcd(ex[i]), req, $sformatf("field %0d", i + 1));
    end
  endtask

  task automatic to_second();
    do step(1, 0, 0, 0); while (!last_pulse);
  endtask

  task automatic to_edge();
    while (bpre != DIV - 1) step(1, 0, 0, 0);
  endtask

  task automatic set_time(int yr, int mo, int dt, int dw, int hr, int mi, int se);
    int vals[7];
    vals = '{se, mi, hr, dw, dt, mo, yr};
    step(0, 1, 0, 2);
    for (int i = 0; i < 7; i++) step(0, 1, i + 1, tobcd(vals[i]));
    step(0, 1, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    int yrs[4];
    yrs = '{0, 1, 4, 99};
    bt = '{0, 0, 0, 1, 1, 1, 0};
    staged = bt;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R11 R5: reset state through the register map
    rd(0, v); chk(v, 0, "R11", "control");
    ex = bt; check_time("R11");

    // R1 R6: DIV-1 ticks leave seconds at 00, the DIV-th tick shows 01
    for (int i = 0; i < DIV - 1; i++) step(1, 0, 0, 0);
    rd(1, v); chk(v, 8'h00, "R1", "before period");
    step(1, 0, 0, 0);
    rd(1, v); chk(v, 8'h01, "R6", "live second");

    // R2 R3 R4: last second of every month for several years
    foreach (yrs[k]) begin
      for (int mo = 1; mo <= 12; mo++) begin
        set_time(yrs[k], mo, mdays(mo, yrs[k]), 7, 23, 59, 58);
        to_second(); ex = bt; check_time("R2");
        to_second(); ex = bt; check_time("R4");
        chk(bt[3], 1, "R3", "model weekday");
      end
    end

    // R2: mid-day minute carry
    set_time(23, 6, 15, 3, 10, 59, 59);
    to_second(); ex = bt; check_time("R2");

    // R9: field write with lock clear is ignored
    ex = bt;
    step(0, 1, 1, 8'h33);
    rd(1, v); chk(v, tobcd(ex[0]), "R9", "ignored write");

    // R7: snapshot frozen while the core moves on
    step(0, 1, 0, 1);
    ex = bt;
    to_second(); to_second();
    check_time("R7");
    rd(0, v); chk(v, 1, "R5", "control snap bit");
    step(0, 1, 0, 0);
    ex = bt; check_time("R6");

    // R8: snapshot rise in the same cycle as a second enable
    to_edge();
    step(1, 1, 0, 1);
    chk(int'(last_pulse), 1, "R8", "pulse aligned");
    ex = bt;
    to_second();
    check_time("R8");
    step(0, 1, 0, 0);

    // R9 R10: lock, stage, tick through the lock, commit with a coincident second
    step(0, 1, 0, 2);
    step(0, 1, 1, 8'h10);
    for (int i = 0; i < 2 * DIV; i++) step(1, 0, 0, 0);
    to_edge();
    step(1, 1, 0, 0);
    chk(int'(last_pulse), 1, "R10", "pulse aligned");
    rd(1, v); chk(v, 8'h10, "R10", "commit value");
    rd(0, v); chk(v, 0, "R10", "control cleared");
    to_second();
    rd(1, v); chk(v, 8'h11, "R1", "phase kept after commit");
    ex = bt; check_time("R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule